// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the address-phase front end of an I2C slave. It watches the SCL and SDA lines after resynchronising them to the system clock, spots START, repeated START and STOP conditions, and shifts in address bytes MSB first. Each byte is compared against a programmable 7-bit own address, the general call address, or a two-byte 10-bit address. A matching byte is acknowledged by pulling SDA low through the ninth clock pulse. A byte that does not match is left unacknowledged, and the bus is then ignored until the next START or STOP.

The 10-bit path takes two steps. A header byte `11110xx0`, whose two `xx` bits equal bits [2:1] of the address register, is acknowledged. The next byte is acknowledged if it equals the extended address register. Neither step raises the interrupt. The interrupt fires when the byte after that has been shifted in, and the block then enters slave mode. After a repeated START, a header `11110xx1` with matching upper bits addresses the same device again for a read.

The states are IDLE (bus free), HDR (first address byte), EXT (second 10-bit byte), TAIL (byte after a 10-bit match), ACK_SETUP (waiting for SCL low before driving), ACK_DRIVE (pulling SDA, waiting for the ninth rise), ACK_END (pulling SDA, waiting for the ninth fall), SLAVE (addressed) and IGNORE (not addressed). The transitions are as follows. STOP leads from any state to IDLE, and START from any state to HDR. The eighth bit in HDR or EXT leads to ACK_SETUP on a match and to IGNORE otherwise. The eighth bit in TAIL leads to SLAVE. ACK_SETUP moves to ACK_DRIVE on an SCL fall, ACK_DRIVE to ACK_END on an SCL rise, and ACK_END moves on an SCL fall to EXT, TAIL or SLAVE, as recorded when the byte matched.

Top module: `i2c_addr_match`

## Requirements
- R1: Both address registers reset to 00h. Each can be written and read back: `reg_sel`=0 selects the slave address register and `reg_sel`=1 the extended address register.
- R2: When a first byte has bits [7:1] equal to slave address bits [7:1], and those bits are not all zero, the byte is acknowledged. `irq` then pulses, `slave_active` and `own_match` go high, and `rd_dir` equals bit 0 of the byte.
- R3: A first byte that matches nothing is not acknowledged. No further byte is acknowledged until a new START, after which matching resumes.
- R4: The byte 00h is acknowledged with `gen_call`=1 and `own_match`=0 only when slave address bit 0 is 1. The bytes 00h with that bit clear and 01h are never acknowledged.
- R5: A first byte `11110xx0` whose `xx` equals slave address bits [2:1] is acknowledged without an `irq` pulse. A mismatch in `xx` gets no acknowledge.
- R6: After R5, a second byte equal to the extended address register is acknowledged without `irq`. Any other value is not acknowledged.
- R7: After R6, the next byte produces an `irq` pulse, with `slave_active`=1, `own_match`=1 and `rd_dir`=0.
- R8: After R6, a repeated START and then `11110xx1` with matching `xx` is acknowledged, with an `irq` pulse and `rd_dir`=1. The same byte is not acknowledged if no 10-bit match has happened since the last STOP.
- R9: `sda_pull` changes only after an SCL fall (or a START or STOP). It stays high from the fall after the eighth bit to the fall after the ninth pulse, and is low once that byte ends.
- R10: STOP clears `slave_active` and releases SDA. `irq` is a single-cycle pulse.
- R11: A register write that lands in the cycle in which the eighth bit is taken does not affect that byte's comparison. It applies from the next address byte on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_sel | input | 1 | 0 slave address register, 1 extended address register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Contents of the selected register |
| irq | output | 1 | One-cycle pulse when the device becomes addressed |
| slave_active | output | 1 | Device is addressed (slave mode) |
| rd_dir | output | 1 | 1 = master reads, valid while addressed |
| gen_call | output | 1 | Addressed by general call |
| own_match | output | 1 | Addressed by own 7-bit or 10-bit address |

## Verification
A CPU write to the slave address register can fall in exactly the cycle in which the synchronised eighth SCL rise makes the address decision. The bench times this case by counting the two synchroniser stages from the edge where it raises SCL. It holds `wr_en` for that one cycle only, with a value that would no longer match. It then expects an acknowledge based on the old value, and expects the new value to decide the next transaction.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_EXT,
        ST_TAIL,
        ST_ACK_SETUP,
        ST_ACK_DRIVE,
        ST_ACK_END,
        ST_SLAVE,
        ST_IGNORE
    } am_state_e;

    typedef enum logic [1:0] {
        NX_EXT,
        NX_TAIL,
        NX_SLAVE
    } ack_next_e;

    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;
    localparam int SCL_I = 0;
    localparam int SDA_I = 1;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prv;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end
        assign cur[g] = chain[STAGES-1];
        assign prv[g] = last;
    end

    assign sda_s     = cur[SDA_I];
    assign scl_rise  =  cur[SCL_I] & ~prv[SCL_I];
    assign scl_fall  = ~cur[SCL_I] &  prv[SCL_I];
    assign start_det =  cur[SCL_I] &  prv[SCL_I] &  prv[SDA_I] & ~cur[SDA_I];
    assign stop_det  =  cur[SCL_I] &  prv[SCL_I] & ~prv[SDA_I] &  cur[SDA_I];

endmodule

// File: rtl/i2c_am_regs.sv
module i2c_am_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] sar_q,
    output logic [W-1:0] xsar_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q  <= '0;
            xsar_q <= '0;
        end else if (wr_en) begin
            if (reg_sel) xsar_q <= wr_data;
            else         sar_q  <= wr_data;
        end
    end

    assign rd_data = reg_sel ? xsar_q : sar_q;

endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sda_s,
    input  logic         scl_rise,
    input  logic         scl_fall,
    input  logic         start_det,
    input  logic         stop_det,
    input  logic [W-1:0] sar,
    input  logic [W-1:0] xsar,
    output logic         sda_pull,
    output logic         irq,
    output logic         slave_active,
    output logic         rd_dir,
    output logic         gen_call,
    output logic         own_match
);
    localparam int          CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    am_state_e      state_q, state_d;
    ack_next_e      ack_nx_q, ack_nx_d;
    logic [W-1:0]   shreg;
    logic [W-1:0]   nb;
    logic [CW-1:0]  bitcnt;
    logic           ten_q;
    logic           take_bit, last_bit;
    logic           hdr10, hdr_up;
    logic           fire, set_gc, set_own, set_rd, set_ten, clr_ten;

    assign nb       = {shreg[W-2:0], sda_s};
    assign take_bit = scl_rise && (state_q inside {ST_HDR, ST_EXT, ST_TAIL});
    assign last_bit = take_bit && (bitcnt == LAST);
    assign hdr10    = (nb[W-1:W-5] == TEN_BIT_PREFIX);
    assign hdr_up   = (nb[2:1] == sar[2:1]);

    always_comb begin
        state_d  = state_q;
        ack_nx_d = ack_nx_q;
        fire     = 1'b0;
        set_gc   = 1'b0;
        set_own  = 1'b0;
        set_rd   = 1'b0;
        set_ten  = 1'b0;
        clr_ten  = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_HDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SLAVE, ST_IGNORE: begin
                end
                ST_HDR: begin
                    if (last_bit) begin
                        if (hdr10) begin
                            if (!nb[0] && hdr_up) begin
                                state_d  = ST_ACK_SETUP;
                                ack_nx_d = NX_EXT;
                                clr_ten  = 1'b1;
                            end else if (nb[0] && hdr_up && ten_q) begin
                                state_d  = ST_ACK_SETUP;
                                ack_nx_d = NX_SLAVE;
                                fire     = 1'b1;
                                set_own  = 1'b1;
                                set_rd   = 1'b1;
                            end else begin
                                state_d  = ST_IGNORE;
                                clr_ten  = 1'b1;
                            end
                        end else if (nb[W-1:1] == '0) begin
                            if (!nb[0] && sar[0]) begin
                                state_d  = ST_ACK_SETUP;
                                ack_nx_d = NX_SLAVE;
                                fire     = 1'b1;
                                set_gc   = 1'b1;
                            end else begin
                                state_d  = ST_IGNORE;
                            end
                        end else if (nb[W-1:1] == sar[W-1:1]) begin
                            state_d  = ST_ACK_SETUP;
                            ack_nx_d = NX_SLAVE;
                            fire     = 1'b1;
                            set_own  = 1'b1;
                            set_rd   = nb[0];
                        end else begin
                            state_d  = ST_IGNORE;
                        end
                    end
                end
                ST_EXT: begin
                    if (last_bit) begin
                        if (nb == xsar) begin
                            state_d  = ST_ACK_SETUP;
                            ack_nx_d = NX_TAIL;
                            set_ten  = 1'b1;
                        end else begin
                            state_d  = ST_IGNORE;
                        end
                    end
                end
                ST_TAIL: begin
                    if (last_bit) begin
                        state_d = ST_SLAVE;
                        fire    = 1'b1;
                        set_own = 1'b1;
                    end
                end
                ST_ACK_SETUP: begin
                    if (scl_fall) state_d = ST_ACK_DRIVE;
                end
                ST_ACK_DRIVE: begin
                    if (scl_rise) state_d = ST_ACK_END;
                end
                ST_ACK_END: begin
                    if (scl_fall) begin
                        unique case (ack_nx_q)
                            NX_EXT:  state_d = ST_EXT;
                            NX_TAIL: state_d = ST_TAIL;
                            default: state_d = ST_SLAVE;
                        endcase
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ack_nx_q <= NX_SLAVE;
        end else begin
            state_q  <= state_d;
            ack_nx_q <= ack_nx_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg        <= '0;
            bitcnt       <= '0;
            ten_q        <= 1'b0;
            irq          <= 1'b0;
            slave_active <= 1'b0;
            rd_dir       <= 1'b0;
            gen_call     <= 1'b0;
            own_match    <= 1'b0;
        end else if (stop_det || start_det) begin
            bitcnt       <= '0;
            irq          <= 1'b0;
            slave_active <= 1'b0;
            rd_dir       <= 1'b0;
            gen_call     <= 1'b0;
            own_match    <= 1'b0;
            if (stop_det) ten_q <= 1'b0;
        end else begin
            irq <= fire;
            if (fire) begin
                slave_active <= 1'b1;
                gen_call     <= set_gc;
                own_match    <= set_own;
                rd_dir       <= set_rd;
            end
            if (take_bit) begin
                shreg  <= nb;
                bitcnt <= bitcnt + 1'b1;
            end else if (state_q == ST_ACK_END && scl_fall) begin
                bitcnt <= '0;
            end
            if (clr_ten)      ten_q <= 1'b0;
            else if (set_ten) ten_q <= 1'b1;
        end
    end

    always_comb begin
        sda_pull = (state_q == ST_ACK_DRIVE) || (state_q == ST_ACK_END);
    end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_in,
    input  logic         sda_in,
    output logic         sda_pull,
    input  logic         reg_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         irq,
    output logic         slave_active,
    output logic         rd_dir,
    output logic         gen_call,
    output logic         own_match
);
    logic         sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [W-1:0] sar_q, xsar_q;

    i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_am_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .sar_q   (sar_q),
        .xsar_q  (xsar_q)
    );

    i2c_am_fsm #(.W(W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sar          (sar_q),
        .xsar         (xsar_q),
        .sda_pull     (sda_pull),
        .irq          (irq),
        .slave_active (slave_active),
        .rd_dir       (rd_dir),
        .gen_call     (gen_call),
        .own_match    (own_match)
    );

endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic slave_active,
    input logic sda_pull,
    input logic rd_dir,
    input logic gen_call,
    input logic own_match,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic gce_bit
);
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_enter_slave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slave_active) |-> irq);

    p_pull_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));

    p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!slave_active && !sda_pull));

    p_status_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gen_call, own_match}));

    p_gc_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_call) |-> $past(gce_bit));

    p_dir_needs_slave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dir |-> slave_active);

endmodule

bind i2c_addr_match i2c_am_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .slave_active (slave_active),
    .sda_pull     (sda_pull),
    .rd_dir       (rd_dir),
    .gen_call     (gen_call),
    .own_match    (own_match),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .gce_bit      (sar_q[0])
);

// File: tb/test_i2c_addr_match.sv
`timescale 1ns/1ps
module test_i2c_addr_match;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_in;
    logic       sda_pull;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq, slave_active, rd_dir, gen_call, own_match;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;

    always #10 clk = ~clk;

    assign sda_in = m_sda & ~sda_pull;

    i2c_addr_match i_i2c_addr_match (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_in),
        .sda_pull(sda_pull), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .slave_active(slave_active), .rd_dir(rd_dir),
        .gen_call(gen_call), .own_match(own_match)
    );

    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    // {slave addr reg, byte, exp ack, exp irq, exp gen_call, exp rd_dir}
    localparam logic [19:0] VEC [7] = '{
        {8'h84, 8'h84, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h84, 8'h85, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h84, 8'h86, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h85, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h84, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h85, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_start;
        m_sda = 1'b1; waitq(Q);
        scl = 1'b1;   waitq(Q);
        m_sda = 1'b0; waitq(Q);
        scl = 1'b0;   waitq(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; waitq(Q);
        scl = 1'b1;   waitq(Q);
        m_sda = 1'b1; waitq(Q);
    endtask

    // hook=1: write wr_val to the slave address register in the decision cycle of bit 8
    task automatic send_byte(input logic [7:0] b, output logic ack,
                             input bit hook, input logic [7:0] wr_val);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; waitq(Q);
            scl = 1'b1;
            if (hook && i == 0) begin
                @(negedge clk);
                @(negedge clk);
                reg_sel = 1'b0; wr_en = 1'b1; wr_data = wr_val;
                @(negedge clk);
                wr_en = 1'b0;
                waitq(Q - 3);
            end else begin
                waitq(Q);
            end
            scl = 1'b0; waitq(Q);
        end
        m_sda = 1'b1; waitq(Q);
        scl = 1'b1;   waitq(Q / 2);
        ack = ~sda_in;
        waitq(Q - Q / 2);
        scl = 1'b0;   waitq(Q);
        chk("R9 sda released after byte", {7'd0, sda_pull}, 8'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic ack;
        int   base;
        waitq(3);
        // Reset state
        chk("R1 sda_pull at reset", {7'd0, sda_pull}, 8'd0);
        chk("R10 irq at reset", {7'd0, irq}, 8'd0);
        rst_n = 1'b1;
        waitq(2);
        reg_sel = 1'b0; @(negedge clk);
        chk("R1 slave addr reg reset", rd_data, 8'h00);
        reg_sel = 1'b1; @(negedge clk);
        chk("R1 ext addr reg reset", rd_data, 8'h00);
        chk("R2 slave_active at reset", {7'd0, slave_active}, 8'd0);
        reg_wr(1'b0, 8'hA5);
        reg_wr(1'b1, 8'h3C);
        reg_sel = 1'b0; @(negedge clk);
        chk("R1 slave addr readback", rd_data, 8'hA5);
        reg_sel = 1'b1; @(negedge clk);
        chk("R1 ext addr readback", rd_data, 8'h3C);

        // Vector table: 7-bit and general call recognition
        for (int v = 0; v < 7; v++) begin
            string tag;
            tag = (VEC[v][11:5] == 7'd0) ? "R4" : (VEC[v][3] ? "R2" : "R3");
            reg_wr(1'b0, VEC[v][19:12]);
            base = irq_cnt;
            bus_start;
            send_byte(VEC[v][11:4], ack, 1'b0, 8'h00);
            chk({tag, " ack"}, {7'd0, ack}, {7'd0, VEC[v][3]});
            chk({tag, " irq count"}, 8'(irq_cnt - base), {7'd0, VEC[v][2]});
            chk({tag, " slave_active"}, {7'd0, slave_active}, {7'd0, VEC[v][2]});
            if (VEC[v][2]) begin
                chk({tag, " gen_call"}, {7'd0, gen_call}, {7'd0, VEC[v][1]});
                chk({tag, " own_match"}, {7'd0, own_match}, {7'd0, ~VEC[v][1]});
                chk({tag, " rd_dir"}, {7'd0, rd_dir}, {7'd0, VEC[v][0]});
            end
            bus_stop;
            chk("R10 slave_active after STOP", {7'd0, slave_active}, 8'd0);
        end

        // R3: ignore after mismatch, recover on repeated START
        reg_wr(1'b0, 8'h84);
        base = irq_cnt;
        bus_start;
        send_byte(8'h86, ack, 1'b0, 8'h00);
        chk("R3 mismatch nack", {7'd0, ack}, 8'd0);
        send_byte(8'h84, ack, 1'b0, 8'h00);
        chk("R3 ignored byte not acked", {7'd0, ack}, 8'd0);
        chk("R3 no irq while ignoring", 8'(irq_cnt - base), 8'd0);
        bus_start;
        send_byte(8'h84, ack, 1'b0, 8'h00);
        chk("R3 match after new START", {7'd0, ack}, 8'd1);
        bus_stop;

        // 10-bit write then repeated START read
        reg_wr(1'b0, 8'h04);
        reg_wr(1'b1, 8'h5A);
        base = irq_cnt;
        bus_start;
        send_byte(8'hF4, ack, 1'b0, 8'h00);
        chk("R5 header ack", {7'd0, ack}, 8'd1);
        chk("R5 no irq on header", 8'(irq_cnt - base), 8'd0);
        send_byte(8'h5A, ack, 1'b0, 8'h00);
        chk("R6 ext byte ack", {7'd0, ack}, 8'd1);
        chk("R6 no irq on ext byte", 8'(irq_cnt - base), 8'd0);
        chk("R6 not yet slave", {7'd0, slave_active}, 8'd0);
        send_byte(8'h33, ack, 1'b0, 8'h00);
        chk("R7 irq after next byte", 8'(irq_cnt - base), 8'd1);
        chk("R7 slave_active", {7'd0, slave_active}, 8'd1);
        chk("R7 own_match", {7'd0, own_match}, 8'd1);
        chk("R7 rd_dir write", {7'd0, rd_dir}, 8'd0);
        bus_start;
        send_byte(8'hF5, ack, 1'b0, 8'h00);
        chk("R8 read header ack", {7'd0, ack}, 8'd1);
        chk("R8 irq on read header", 8'(irq_cnt - base), 8'd2);
        chk("R8 rd_dir read", {7'd0, rd_dir}, 8'd1);
        bus_stop;
        chk("R10 released after STOP", {7'd0, slave_active}, 8'd0);

        // R8: read header without a prior 10-bit match
        bus_start;
        send_byte(8'hF5, ack, 1'b0, 8'h00);
        chk("R8 read header without match nack", {7'd0, ack}, 8'd0);
        bus_stop;

        // R5: wrong upper bits; R6: wrong ext byte
        base = irq_cnt;
        bus_start;
        send_byte(8'hF2, ack, 1'b0, 8'h00);
        chk("R5 wrong upper bits nack", {7'd0, ack}, 8'd0);
        bus_stop;
        bus_start;
        send_byte(8'hF4, ack, 1'b0, 8'h00);
        send_byte(8'h5B, ack, 1'b0, 8'h00);
        chk("R6 wrong ext byte nack", {7'd0, ack}, 8'd0);
        chk("R6 no irq on mismatches", 8'(irq_cnt - base), 8'd0);
        bus_stop;

        // R11: write in the decision cycle
        reg_wr(1'b0, 8'h84);
        bus_start;
        send_byte(8'h84, ack, 1'b1, 8'h90);
        chk("R11 old value decides", {7'd0, ack}, 8'd1);
        bus_stop;
        bus_start;
        send_byte(8'h84, ack, 1'b0, 8'h00);
        chk("R11 new value applies next", {7'd0, ack}, 8'd0);
        bus_stop;
        bus_start;
        send_byte(8'h90, ack, 1'b0, 8'h00);
        chk("R11 new address acked", {7'd0, ack}, 8'd1);
        bus_stop;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule